// File: doc/BRIEF.md
# SPI Flash Boot-Window Controller

This block sits between a simple CPU bus slave port and an external SPI NOR flash. After reset it runs in direct-map mode. Each bus read inside a 16 MiB window becomes a complete flash read frame: chip select 0 is pulled low, the read command and a 24-bit address are shifted out, 32 data bits are shifted in, and chip select 0 is released. The bus read is stalled until the word is available. While mirroring is active, only the lowest 4 MiB of flash is seen, repeated across the whole window, so a boot vector placed high in the window still lands at the start of flash. Setting a remap-disable bit turns this into a linear 16 MiB map.

A write to window offset 0 selects the mode. In register mode the window shows four word registers instead of flash: mode select, control, pin control and received data. Software then drives the three chip selects, the serial clock and the data-out line directly through the pin-control register. Hardware still helps in one way: a 32-bit capture register shifts in the data-in line on every rising serial-clock edge, whichever mode is driving the pins.

The serial interface works only with clock idle high and data sampled on the rising edge. In direct-map mode the serial clock runs at the system clock divided by `SCK_DIV`.

Top module: `sfbw_ctrl`

## Requirements
- R1: After reset the block is in direct-map mode with mirroring on. All chip selects are high, SCK is high and MOSI is low. In register mode after reset, offset 12 reads 0, offset 4 reads 0 and offset 8 reads 0x00070100.
- R2: A direct-map read produces one frame on chip select 0. The frame is the command byte 0x03, then 24 address bits MSB first, then 32 data clocks, which is exactly 64 rising SCK edges. Chip selects 1 and 2 stay high throughout, and chip select 0 returns high after the frame.
- R3: With remap-disable clear, the flash address is the bus address modulo 4 MiB (the upper two address bits are forced to zero).
- R4: With remap-disable set (control register offset 4, bit 0), the flash address is the full 24-bit bus address.
- R5: A direct-map read stalls. `bus_ready` rises only after the whole frame, at least 64*SCK_DIV cycles later, as a one-cycle pulse. `bus_rdata` then returns the 32 received bits, with the first bit received in bit 31.
- R6: In direct-map mode SCK idles high whenever chip select 0 is high. Consecutive rising SCK edges within a frame are SCK_DIV system clocks apart.
- R7: Writing to offset 0 with bit 0 = 1 enters register mode, and with bit 0 = 0 returns to direct-map mode. In direct-map mode the pins show the sequencer's idle levels whatever the pin-control register holds. Offset 0 reads as 0.
- R8: In register mode, pin-control (offset 8) bits 16, 17 and 18 drive chip selects 0, 1 and 2 (1 = deselected), bit 8 drives SCK and bit 0 drives MOSI. The pins change one cycle after the write completes.
- R9: The capture register (offset 12, read-only) shifts MISO in at bit 0 on each rising SCK edge and does not shift on falling edges. It keeps only the latest 32 bits, so the first byte of a 4-byte run ends in bits 31:24 and a shorter run sits in the low bytes. It is shared with the direct-map sequencer.
- R10: In direct-map mode, bus writes to any offset other than 0 complete but change nothing.
- R11: In register mode, the control and pin-control registers read back the values last written to their defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request; held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | WIN_AW | Byte offset inside the window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| spi_csn | output | NUM_CS | Active-low chip selects |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A wrong mode bit shows up as soon as the next bus access. A direct read then returns register contents with almost no latency, or a register access starts a flash frame. A fault in the half-period counter or bit counter shows up within one frame: the rising SCK edges are mis-spaced, or there are not exactly 64 of them before chip select 0 rises. A wrong address mask shows up at the flash model as a wrong captured address and, one frame later, as a wrong returned word. A capture register that shifts on the wrong edge or in the wrong direction shows up on the very next read of offset 12.

// File: rtl/sfbw_pkg.sv
package sfbw_pkg;

   // Register word selected by bus_addr[3:2] in register mode
   typedef enum logic [1:0] {
      REG_FSEL  = 2'd0,
      REG_CTRL  = 2'd1,
      REG_IOCTL = 2'd2,
      REG_RDATA = 2'd3
   } reg_sel_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LEAD,
      SQ_BITS,
      SQ_TAIL,
      SQ_DONE
   } seq_state_e;

   typedef enum logic {
      BS_IDLE,
      BS_WAIT
   } bus_state_e;

   localparam logic [7:0] FLASH_READ_CMD = 8'h03;
   localparam int         CMD_W          = 8;
   localparam int         IOC_CS_LSB     = 16;
   localparam int         IOC_SCK_BIT    = 8;
   localparam int         IOC_DO_BIT     = 0;
   localparam int         CTRL_REMAP_BIT = 0;

endpackage

// File: rtl/sfbw_capture.sv
module sfbw_capture #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          miso,
   output logic [DW-1:0] data
);

   if (DW < 8) begin : g_bad_dw
      $error("sfbw_capture: DW must be at least 8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data <= '0;
      else if (shift_en) data <= {data[DW-2:0], miso};
   end

   // R9: no rising clock edge, no change in the captured bits
   a_r9_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(data));

endmodule

// File: rtl/sfbw_seq.sv
module sfbw_seq
   import sfbw_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int DW      = 32,
   parameter int SCK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic              cs_n,
   output logic              sck,
   output logic              mosi,
   output logic              done
);

   localparam int HALF       = SCK_DIV / 2;
   localparam int TX_W       = CMD_W + ADDR_W;
   localparam int FRAME_BITS = TX_W + DW;
   localparam int BCW        = $clog2(FRAME_BITS);
   localparam int HCW        = (HALF > 1) ? $clog2(HALF) : 1;

   if (SCK_DIV < 2 || (SCK_DIV % 2) != 0) begin : g_bad_div
      $error("sfbw_seq: SCK_DIV must be even and at least 2");
   end

   seq_state_e      state;
   logic [TX_W-1:0] tx;
   logic [BCW-1:0]  bitcnt;
   logic            hi;
   logic            half_end;
   logic            timing;

   assign timing = (state == SQ_LEAD) || (state == SQ_BITS) || (state == SQ_TAIL);

   // Half-period timer: absent when a half period is one system clock
   if (HALF == 1) begin : g_half_one
      assign half_end = 1'b1;
   end else begin : g_half_cnt
      logic [HCW-1:0] hcnt;
      assign half_end = (hcnt == HCW'(HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hcnt <= '0;
         else if (!timing || half_end) hcnt <= '0;
         else hcnt <= hcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         tx     <= '0;
         bitcnt <= '0;
         hi     <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: if (start) begin
               tx     <= {FLASH_READ_CMD, addr};
               bitcnt <= '0;
               hi     <= 1'b0;
               state  <= SQ_LEAD;
            end
            SQ_LEAD: if (half_end) state <= SQ_BITS;
            SQ_BITS: if (half_end) begin
               if (!hi) hi <= 1'b1;
               else begin
                  hi <= 1'b0;
                  tx <= {tx[TX_W-2:0], 1'b0};
                  if (bitcnt == BCW'(FRAME_BITS - 1)) state <= SQ_TAIL;
                  else bitcnt <= bitcnt + 1'b1;
               end
            end
            SQ_TAIL: if (half_end) state <= SQ_DONE;
            SQ_DONE: state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign cs_n = (state == SQ_IDLE) || (state == SQ_DONE);
   assign sck  = !((state == SQ_BITS) && !hi);
   assign mosi = (state == SQ_BITS) ? tx[TX_W-1] : 1'b0;
   assign done = (state == SQ_DONE);

   // R2: the trailing phase is entered only after the full frame of bits
   a_r2_frame_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_TAIL) |-> (bitcnt == BCW'(FRAME_BITS - 1)));
   // R6: the clock only drops while the flash is selected
   a_r6_sck_low_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !sck |-> !cs_n);

endmodule

// File: rtl/sfbw_regs.sv
module sfbw_regs
   import sfbw_pkg::*;
#(
   parameter int DW     = 32,
   parameter int NUM_CS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  reg_sel_e          sel,
   input  logic [DW-1:0]     wdata,
   input  logic [DW-1:0]     cap_data,
   output logic              reg_mode,
   output logic              remap_dis,
   output logic [NUM_CS-1:0] ioc_csn,
   output logic              ioc_sck,
   output logic              ioc_mosi,
   output logic [DW-1:0]     rdata
);

   if (NUM_CS < 1 || IOC_CS_LSB + NUM_CS > DW) begin : g_bad_cs
      $error("sfbw_regs: chip-select field does not fit the data width");
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_mode  <= 1'b0;
         remap_dis <= 1'b0;
         ioc_csn   <= '1;
         ioc_sck   <= 1'b1;
         ioc_mosi  <= 1'b0;
      end else if (wr_stb) begin
         case (sel)
            REG_FSEL:  reg_mode  <= wdata[0];
            REG_CTRL:  remap_dis <= wdata[CTRL_REMAP_BIT];
            REG_IOCTL: begin
               ioc_csn  <= wdata[IOC_CS_LSB +: NUM_CS];
               ioc_sck  <= wdata[IOC_SCK_BIT];
               ioc_mosi <= wdata[IOC_DO_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         REG_CTRL:  rdata[CTRL_REMAP_BIT] = remap_dis;
         REG_IOCTL: begin
            rdata[IOC_CS_LSB +: NUM_CS] = ioc_csn;
            rdata[IOC_SCK_BIT]          = ioc_sck;
            rdata[IOC_DO_BIT]           = ioc_mosi;
         end
         REG_RDATA: rdata = cap_data;
         default:   rdata = '0;
      endcase
   end

   // R8: pin-control state moves only on a write strobe
   a_r8_ioc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable({ioc_csn, ioc_sck, ioc_mosi}));

endmodule

// File: rtl/sfbw_ctrl.sv
module sfbw_ctrl
   import sfbw_pkg::*;
#(
   parameter int WIN_AW  = 24,
   parameter int BOOT_AW = 22,
   parameter int DW      = 32,
   parameter int NUM_CS  = 3,
   parameter int SCK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [WIN_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              bus_ready,
   output logic [NUM_CS-1:0] spi_csn,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   if (BOOT_AW > WIN_AW || WIN_AW < 4) begin : g_bad_aw
      $error("sfbw_ctrl: BOOT_AW must not exceed WIN_AW, WIN_AW at least 4");
   end

   bus_state_e        bs_state;
   logic              accept;
   logic              seq_start;
   logic              wr_stb;
   reg_sel_e          sel;
   logic              reg_mode;
   logic              remap_dis;
   logic [NUM_CS-1:0] ioc_csn;
   logic              ioc_sck;
   logic              ioc_mosi;
   logic [DW-1:0]     reg_rdata;
   logic [DW-1:0]     cap_data;
   logic [WIN_AW-1:0] flash_addr;
   logic              seq_csn;
   logic              seq_sck;
   logic              seq_mosi;
   logic              seq_done;
   logic [NUM_CS-1:0] csn_next;
   logic              sck_next;
   logic              mosi_next;
   logic              shift_en;

   assign sel       = reg_sel_e'(bus_addr[3:2]);
   assign accept    = (bs_state == BS_IDLE) && bus_req && !bus_ready;
   assign seq_start = accept && !reg_mode && !bus_we;
   assign wr_stb    = accept && bus_we &&
                      (reg_mode || (bus_addr[WIN_AW-1:2] == '0));

   // Mirroring of the boot region, or a straight map when it covers the window
   if (BOOT_AW < WIN_AW) begin : g_mirror
      localparam logic [WIN_AW-1:0] BOOT_MASK =
         WIN_AW'((64'd1 << BOOT_AW) - 64'd1);
      assign flash_addr = remap_dis ? bus_addr : (bus_addr & BOOT_MASK);
   end else begin : g_flat
      logic unused_remap;
      assign unused_remap = remap_dis;
      assign flash_addr   = bus_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bs_state  <= BS_IDLE;
         bus_ready <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ready <= 1'b0;
         case (bs_state)
            BS_IDLE: if (accept) begin
               if (seq_start) bs_state <= BS_WAIT;
               else begin
                  bus_ready <= 1'b1;
                  bus_rdata <= (reg_mode && !bus_we) ? reg_rdata : '0;
               end
            end
            BS_WAIT: if (seq_done) begin
               bus_ready <= 1'b1;
               bus_rdata <= cap_data;
               bs_state  <= BS_IDLE;
            end
            default: bs_state <= BS_IDLE;
         endcase
      end
   end

   sfbw_regs #(.DW(DW), .NUM_CS(NUM_CS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .sel      (sel),
      .wdata    (bus_wdata),
      .cap_data (cap_data),
      .reg_mode (reg_mode),
      .remap_dis(remap_dis),
      .ioc_csn  (ioc_csn),
      .ioc_sck  (ioc_sck),
      .ioc_mosi (ioc_mosi),
      .rdata    (reg_rdata)
   );

   sfbw_seq #(.ADDR_W(WIN_AW), .DW(DW), .SCK_DIV(SCK_DIV)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .start(seq_start),
      .addr (flash_addr),
      .cs_n (seq_csn),
      .sck  (seq_sck),
      .mosi (seq_mosi),
      .done (seq_done)
   );

   // Pin source selection: software fields or the read sequencer
   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      if (i == 0) begin : g_boot
         assign csn_next[i] = reg_mode ? ioc_csn[i] : seq_csn;
      end else begin : g_side
         assign csn_next[i] = reg_mode ? ioc_csn[i] : 1'b1;
         // R2: side chip selects stay released while direct mapping drives pins
         a_r2_side_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!reg_mode) |-> spi_csn[i]);
      end
   end

   assign sck_next  = reg_mode ? ioc_sck  : seq_sck;
   assign mosi_next = reg_mode ? ioc_mosi : seq_mosi;
   assign shift_en  = sck_next && !spi_sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_csn  <= '1;
         spi_sck  <= 1'b1;
         spi_mosi <= 1'b0;
      end else begin
         spi_csn  <= csn_next;
         spi_sck  <= sck_next;
         spi_mosi <= mosi_next;
      end
   end

   sfbw_capture #(.DW(DW)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .miso    (spi_miso),
      .data    (cap_data)
   );

   // R5: completion is a single-cycle pulse
   a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);
   // R6: clock idles high whenever the boot flash is released in direct-map mode
   a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_mode && $past(!reg_mode) && spi_csn[0]) |-> spi_sck);

endmodule

// File: tb/sfbw_ctrl_tb.sv
module sfbw_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic [2:0]  spi_csn;
   logic        spi_sck;
   logic        spi_mosi;
   logic        spi_miso;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sfbw_ctrl u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .bus_ready(bus_ready),
      .spi_csn  (spi_csn),
      .spi_sck  (spi_sck),
      .spi_mosi (spi_mosi),
      .spi_miso (spi_miso)
   );

   // Flash model: mode 3, read command only
   function automatic logic [31:0] fm_word(input logic [23:0] a);
      return {a[7:0], a[23:16], a[15:8], 8'hC3} ^ 32'h5A5A_0F0F;
   endfunction

   int          fm_cnt = 0;
   logic [31:0] fm_rx = '0;
   logic        fm_miso = 1'b0;
   logic        bb_miso = 1'b0;
   time         fm_last = 0;
   time         fm_period = 0;
   int          fm_idx;
   logic [31:0] fm_tmp;

   assign spi_miso = !spi_csn[0] ? fm_miso : bb_miso;

   always @(negedge spi_csn[0]) begin
      fm_cnt  = 0;
      fm_miso = 1'b0;
   end

   always @(posedge spi_sck) begin
      if (!spi_csn[0]) begin
         if (fm_cnt < 32) fm_rx = {fm_rx[30:0], spi_mosi};
         if (fm_cnt > 0) fm_period = $time - fm_last;
         fm_last = $time;
         fm_cnt++;
      end
   end

   always @(negedge spi_sck) begin
      if (!spi_csn[0] && fm_cnt >= 32 && fm_cnt < 64) begin
         fm_tmp  = fm_word(fm_rx[23:0]);
         fm_idx  = 63 - fm_cnt;
         fm_miso = fm_tmp[fm_idx];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [23:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      do @(negedge clk); while (!bus_ready);
      bus_req = 1'b0; bus_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic bus_rd(input logic [23:0] a, output logic [31:0] d, output int lat);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!bus_ready);
      d = bus_rdata;
      bus_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic bb_byte(input logic [7:0] b);
      for (int j = 7; j >= 0; j--) begin
         bb_miso = b[j];
         bus_wr(24'h8, 32'h0005_0000 | 32'(b[j]));
         bus_wr(24'h8, 32'h0005_0100 | 32'(b[j]));
      end
   endtask

   logic cur_remap = 1'b0;
   task automatic set_remap(input logic v);
      bus_wr(24'h0, 32'h1);
      bus_wr(24'h4, 32'(v));
      bus_wr(24'h0, 32'h0);
      cur_remap = v;
   endtask

   // {remap-disable, bus address, expected flash address}
   localparam logic [48:0] VEC [8] = '{
      {1'b0, 24'h000000, 24'h000000},
      {1'b0, 24'h400010, 24'h000010},
      {1'b0, 24'hC00000, 24'h000000},
      {1'b0, 24'hFFFFFC, 24'h3FFFFC},
      {1'b0, 24'h923458, 24'h123458},
      {1'b1, 24'h400010, 24'h400010},
      {1'b1, 24'hFFFFFC, 24'hFFFFFC},
      {1'b1, 24'h123454, 24'h123454}
   };

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      logic [31:0] d;
      int lat;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: pin levels after reset
      chk("R1 csn", 32'(spi_csn), 32'h7);
      chk("R1 sck", 32'(spi_sck), 32'h1);
      chk("R1 mosi", 32'(spi_mosi), 32'h0);

      // R10: direct-map writes away from offset 0 do nothing
      bus_wr(24'h8, 32'h0);
      @(negedge clk);
      chk("R10 csn after ignored write", 32'(spi_csn), 32'h7);
      chk("R10 sck after ignored write", 32'(spi_sck), 32'h1);
      bus_wr(24'h4, 32'h1);

      // R7: enter register mode
      bus_wr(24'h0, 32'h1);
      bus_rd(24'hC, d, lat);
      chk("R1 capture cleared", d, 32'h0);
      chk("R7 register access not stalled", 32'(lat < 4), 32'h1);
      bus_rd(24'h4, d, lat);
      chk("R10 control unchanged by direct write", d, 32'h0);
      bus_rd(24'h8, d, lat);
      chk("R1 pin-control reset value", d, 32'h0007_0100);
      bus_rd(24'h0, d, lat);
      chk("R7 mode select reads zero", d, 32'h0);

      // R8: software pin drive
      bus_wr(24'h8, 32'h0005_0001);
      chk("R8 csn", 32'(spi_csn), 32'h5);
      chk("R8 sck low", 32'(spi_sck), 32'h0);
      chk("R8 mosi high", 32'(spi_mosi), 32'h1);
      bus_wr(24'h8, 32'h0003_0100);
      chk("R8 csn second", 32'(spi_csn), 32'h3);
      chk("R8 sck high", 32'(spi_sck), 32'h1);
      chk("R8 mosi low", 32'(spi_mosi), 32'h0);
      bus_rd(24'h8, d, lat);
      chk("R11 pin-control readback", d, 32'h0003_0100);

      // R9: bit-banged capture, five bytes keep the last four
      bb_byte(8'h11); bb_byte(8'h22); bb_byte(8'h33); bb_byte(8'h44); bb_byte(8'h55);
      bus_rd(24'hC, d, lat);
      chk("R9 last four bytes MSB first", d, 32'h2233_4455);
      bb_byte(8'hA5); bb_byte(8'h3C);
      bus_rd(24'hC, d, lat);
      chk("R9 short run in low bytes", d, 32'h4455_A53C);

      // R11: control register
      bus_wr(24'h4, 32'h1);
      bus_rd(24'h4, d, lat);
      chk("R11 control readback", d, 32'h1);
      bus_wr(24'h4, 32'h0);

      // R7: back to direct map, pins return to idle despite cs1 low in pin-control
      bus_wr(24'h0, 32'h0);
      chk("R7 csn idle in direct map", 32'(spi_csn), 32'h7);
      chk("R7 sck idle in direct map", 32'(spi_sck), 32'h1);

      // Table of direct-map reads
      foreach (VEC[k]) begin
         logic        rm;
         logic [23:0] a, ex;
         {rm, a, ex} = VEC[k];
         if (rm != cur_remap) set_remap(rm);
         bus_rd(a, d, lat);
         chk("R2 command byte", 32'(fm_rx[31:24]), 32'h03);
         chk(rm ? "R4 linear address" : "R3 mirrored address", 32'(fm_rx[23:0]), 32'(ex));
         chk("R5 returned word", d, fm_word(ex));
         chk("R5 stall length", 32'(lat >= 256), 32'h1);
         chk("R2 clock count", 32'(fm_cnt), 32'd64);
         chk("R2 csn released", 32'(spi_csn), 32'h7);
         chk("R6 sck period", 32'(fm_period), 32'd80);
         chk("R6 sck idle", 32'(spi_sck), 32'h1);
      end

      // R9: the capture register is shared with the sequencer
      bus_wr(24'h0, 32'h1);
      bus_rd(24'hC, d, lat);
      chk("R9 shared capture after direct read", d, fm_word(24'h123454));

      summary();
   end

endmodule